// File: doc/BRIEF.md
# Programmed-I/O Queue Front-End for a Bus Controller

This block sits between a host register interface and the transfer logic of a serial bus controller that runs without any memory-access path of its own. Every exchange with software goes through plain 32-bit register accesses. The block holds four first-in first-out queues. A command queue stores 64-bit transfer descriptors. A transmit queue stores data the host wants sent. A receive queue stores data collected from the bus. A response queue stores the one-word completion records.

The command register port takes descriptors as two consecutive 32-bit writes and assembles them into one queue entry. The descriptors and responses name their target through an index into a device table held elsewhere, so this block treats them as opaque words. On the core side the block offers the head descriptor and the head transmit word with a valid flag and a pop strobe. It accepts receive data and response records through push strobes, and it reports the free space left in those two queues.

Each queue reports its fill level and compares it with a programmable level. Pushes into a full queue are refused and leave a sticky overflow mark. Host reads from an empty receive or response queue return zero and leave a sticky underflow mark. A soft flush input empties every queue at once.

Top module: `pio_queue_front`

## Requirements
- R1: After a synchronous reset all four fill counts are zero, `desc_valid` and `tx_valid` are low, both host read data registers hold zero, and the overflow, underflow and level flags are all zero.
- R2: The first write to the command port after reset, after a flush or after a completed descriptor is held as the low word. The next command write forms the descriptor {second word, first word} (second word in bits 63:32), and only that second write pushes it into the command queue.
- R3: Each queue returns its entries in the order they were pushed, and each fill count equals the pushes accepted minus the pops taken. A pop from an empty queue is ignored, and a push and a pop may both take effect in the same cycle.
- R4: A push into a full queue is dropped, leaves that queue's contents unchanged, and sets a sticky bit in `ovf_flags` (bit 0 command, bit 1 transmit, bit 2 receive, bit 3 response). The bit clears only on reset. For the command queue the push is the second write of a pair, and a pair refused this way is lost in full.
- R5: A host read of the receive or response queue while it is empty yields zero on the read data port in the next cycle and sets a sticky bit in `udf_flags` (bit 0 receive, bit 1 response). The bit clears only on reset.
- R6: A host read of a non-empty receive or response queue pops the head entry and presents it on the read data port in the cycle after the read strobe. The port keeps that value until the next read.
- R7: `lvl_hit[i]` is high exactly when queue i's fill count is greater than or equal to its programmed level input (bit order as in R4).
- R8: A cycle with `soft_flush` high empties all four queues and discards a half-written command descriptor. Any push, pop or write in that cycle is discarded. A host read in that cycle returns zero without an underflow mark. Sticky flags are kept.
- R9: `rx_free` and `resp_free` equal the queue depth minus the current fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_flush | input | 1 | Empty all queues and drop a partial descriptor |
| cmd_wr_en | input | 1 | Host write strobe for the command port |
| cmd_wr_data | input | DW | Command port write word |
| tx_wr_en | input | 1 | Host write strobe for the transmit port |
| tx_wr_data | input | DW | Transmit port write word |
| rx_rd_en | input | 1 | Host read strobe for the receive port |
| rx_rd_data | output | DW | Registered receive read data |
| resp_rd_en | input | 1 | Host read strobe for the response port |
| resp_rd_data | output | DW | Registered response read data |
| cmd_lvl | input | $clog2(CMD_DEPTH+1) | Command queue level |
| tx_lvl | input | $clog2(TX_DEPTH+1) | Transmit queue level |
| rx_lvl | input | $clog2(RX_DEPTH+1) | Receive queue level |
| resp_lvl | input | $clog2(RESP_DEPTH+1) | Response queue level |
| cmd_count | output | $clog2(CMD_DEPTH+1) | Command queue fill |
| tx_count | output | $clog2(TX_DEPTH+1) | Transmit queue fill |
| rx_count | output | $clog2(RX_DEPTH+1) | Receive queue fill |
| resp_count | output | $clog2(RESP_DEPTH+1) | Response queue fill |
| lvl_hit | output | 4 | Fill at or above level, per queue |
| ovf_flags | output | 4 | Sticky overflow marks |
| udf_flags | output | 2 | Sticky underflow marks |
| desc_valid | output | 1 | Command queue holds a descriptor |
| desc_data | output | 2*DW | Head descriptor |
| desc_pop | input | 1 | Core takes the head descriptor |
| tx_valid | output | 1 | Transmit queue holds a word |
| tx_data | output | DW | Head transmit word |
| tx_pop | input | 1 | Core takes the head transmit word |
| rx_push | input | 1 | Core delivers a received word |
| rx_data | input | DW | Received word |
| rx_free | output | $clog2(RX_DEPTH+1) | Free receive entries |
| resp_push | input | 1 | Core delivers a response record |
| resp_data | input | DW | Response record |
| resp_free | output | $clog2(RESP_DEPTH+1) | Free response entries |

## Verification
The bench goes after the descriptor pairing. A design that pushed on the first word, or swapped the halves, would show wrong `desc_data` and counts. A flush between the two halves would leave a stale low word behind in a faulty design. It also targets simultaneous push and pop on a full or empty queue. Here a wrong priority either loses an entry or invents one. Reads from empty queues must give zero plus a sticky mark. Refused pushes must not overwrite stored data. A level comparison off by one shows up as a wrong `lvl_hit` at the exact boundary count.

// File: rtl/pio_q_pkg.sv
package pio_q_pkg;
  localparam int NQ      = 4;
  localparam int QI_CMD  = 0;
  localparam int QI_TX   = 1;
  localparam int QI_RX   = 2;
  localparam int QI_RESP = 3;
  localparam int NU      = 2;
  localparam int UI_RX   = 0;
  localparam int UI_RESP = 1;
endpackage

// File: rtl/pio_fifo.sv
module pio_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else if (push && full && !flush) ovf <= 1'b1;
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == $past(count)));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/pio_cmd_pack.sv
module pio_cmd_pack #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         push,
  output logic [2*W-1:0] desc
);
  logic         half;
  logic [W-1:0] low;

  assign push = wr_en && half && !flush;
  assign desc = {wr_data, low};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      half <= 1'b0;
      low  <= '0;
    end else if (wr_en) begin
      if (!half) low <= wr_data;
      half <= !half;
    end
  end

  // R2
  pair_gap_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);
endmodule

// File: rtl/pio_rd_port.sv
module pio_rd_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         rd_en,
  input  logic         empty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic [W-1:0] rd_data,
  output logic         udf
);
  assign pop = rd_en && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      udf     <= 1'b0;
    end else if (rd_en) begin
      if (flush || empty) rd_data <= '0;
      else                rd_data <= head;
      if (!flush && empty) udf <= 1'b1;
    end
  end

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !flush) |=> (rd_data == '0 && udf));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/pio_queue_front.sv
module pio_queue_front
  import pio_q_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CMD_DEPTH  = 4,
  parameter int TX_DEPTH   = 8,
  parameter int RX_DEPTH   = 8,
  parameter int RESP_DEPTH = 4,
  localparam int CCW = $clog2(CMD_DEPTH + 1),
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1),
  localparam int PCW = $clog2(RESP_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_flush,
  input  logic            cmd_wr_en,
  input  logic [DW-1:0]   cmd_wr_data,
  input  logic            tx_wr_en,
  input  logic [DW-1:0]   tx_wr_data,
  input  logic            rx_rd_en,
  output logic [DW-1:0]   rx_rd_data,
  input  logic            resp_rd_en,
  output logic [DW-1:0]   resp_rd_data,
  input  logic [CCW-1:0]  cmd_lvl,
  input  logic [TCW-1:0]  tx_lvl,
  input  logic [RCW-1:0]  rx_lvl,
  input  logic [PCW-1:0]  resp_lvl,
  output logic [CCW-1:0]  cmd_count,
  output logic [TCW-1:0]  tx_count,
  output logic [RCW-1:0]  rx_count,
  output logic [PCW-1:0]  resp_count,
  output logic [NQ-1:0]   lvl_hit,
  output logic [NQ-1:0]   ovf_flags,
  output logic [NU-1:0]   udf_flags,
  output logic            desc_valid,
  output logic [2*DW-1:0] desc_data,
  input  logic            desc_pop,
  output logic            tx_valid,
  output logic [DW-1:0]   tx_data,
  input  logic            tx_pop,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_data,
  output logic [RCW-1:0]  rx_free,
  input  logic            resp_push,
  input  logic [DW-1:0]   resp_data,
  output logic [PCW-1:0]  resp_free
);
  logic            cmd_push;
  logic [2*DW-1:0] cmd_desc;
  logic [NQ-1:0]   q_empty, q_full;
  logic            rx_pop, resp_pop;
  logic [DW-1:0]   rx_head, resp_head;

  pio_cmd_pack #(.W(DW)) u_pack (
    .clk(clk), .rst(rst), .flush(soft_flush), .wr_en(cmd_wr_en),
    .wr_data(cmd_wr_data), .push(cmd_push), .desc(cmd_desc));

  pio_fifo #(.WIDTH(2*DW), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst(rst), .flush(soft_flush), .push(cmd_push), .din(cmd_desc),
    .pop(desc_pop), .head(desc_data), .empty(q_empty[QI_CMD]),
    .full(q_full[QI_CMD]), .count(cmd_count), .ovf(ovf_flags[QI_CMD]));

  pio_fifo #(.WIDTH(DW), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk(clk), .rst(rst), .flush(soft_flush), .push(tx_wr_en), .din(tx_wr_data),
    .pop(tx_pop), .head(tx_data), .empty(q_empty[QI_TX]),
    .full(q_full[QI_TX]), .count(tx_count), .ovf(ovf_flags[QI_TX]));

  pio_fifo #(.WIDTH(DW), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk(clk), .rst(rst), .flush(soft_flush), .push(rx_push), .din(rx_data),
    .pop(rx_pop), .head(rx_head), .empty(q_empty[QI_RX]),
    .full(q_full[QI_RX]), .count(rx_count), .ovf(ovf_flags[QI_RX]));

  pio_fifo #(.WIDTH(DW), .DEPTH(RESP_DEPTH)) u_resp_q (
    .clk(clk), .rst(rst), .flush(soft_flush), .push(resp_push), .din(resp_data),
    .pop(resp_pop), .head(resp_head), .empty(q_empty[QI_RESP]),
    .full(q_full[QI_RESP]), .count(resp_count), .ovf(ovf_flags[QI_RESP]));

  pio_rd_port #(.W(DW)) u_rx_rd (
    .clk(clk), .rst(rst), .flush(soft_flush), .rd_en(rx_rd_en),
    .empty(q_empty[QI_RX]), .head(rx_head), .pop(rx_pop),
    .rd_data(rx_rd_data), .udf(udf_flags[UI_RX]));

  pio_rd_port #(.W(DW)) u_resp_rd (
    .clk(clk), .rst(rst), .flush(soft_flush), .rd_en(resp_rd_en),
    .empty(q_empty[QI_RESP]), .head(resp_head), .pop(resp_pop),
    .rd_data(resp_rd_data), .udf(udf_flags[UI_RESP]));

  assign desc_valid = !q_empty[QI_CMD];
  assign tx_valid   = !q_empty[QI_TX];
  assign rx_free    = RCW'(RX_DEPTH) - rx_count;
  assign resp_free  = PCW'(RESP_DEPTH) - resp_count;

  assign lvl_hit[QI_CMD]  = (cmd_count  >= cmd_lvl);
  assign lvl_hit[QI_TX]   = (tx_count   >= tx_lvl);
  assign lvl_hit[QI_RX]   = (rx_count   >= rx_lvl);
  assign lvl_hit[QI_RESP] = (resp_count >= resp_lvl);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cmd_count == '0 && rx_rd_data == '0 && ovf_flags == '0 && udf_flags == '0));
  // R9
  rx_space_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_free == '0) |-> q_full[QI_RX]);
endmodule

// File: tb/test_pio_queue_front.sv
`timescale 1ns/1ps
module test_pio_queue_front;
  localparam int CD = 4, TD = 8, RD = 8, PD = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, soft_flush;
  logic cmd_wr_en, tx_wr_en, rx_rd_en, resp_rd_en;
  logic [31:0] cmd_wr_data, tx_wr_data, rx_rd_data, resp_rd_data;
  logic [2:0] cmd_lvl, resp_lvl, cmd_count, resp_count, resp_free;
  logic [3:0] tx_lvl, rx_lvl, tx_count, rx_count, rx_free;
  logic [3:0] lvl_hit, ovf_flags;
  logic [1:0] udf_flags;
  logic desc_valid, desc_pop, tx_valid, tx_pop, rx_push, resp_push;
  logic [63:0] desc_data;
  logic [31:0] tx_data, rx_data, resp_data;

  pio_queue_front i_pio_queue_front (
    .clk(clk), .rst(rst), .soft_flush(soft_flush),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .resp_rd_en(resp_rd_en), .resp_rd_data(resp_rd_data),
    .cmd_lvl(cmd_lvl), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .resp_lvl(resp_lvl),
    .cmd_count(cmd_count), .tx_count(tx_count), .rx_count(rx_count),
    .resp_count(resp_count), .lvl_hit(lvl_hit), .ovf_flags(ovf_flags),
    .udf_flags(udf_flags), .desc_valid(desc_valid), .desc_data(desc_data),
    .desc_pop(desc_pop), .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .rx_free(rx_free),
    .resp_push(resp_push), .resp_data(resp_data), .resp_free(resp_free));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // reference model
  logic [63:0] m_cmd[$];
  logic [31:0] m_tx[$], m_rx[$], m_resp[$];
  bit m_half;
  logic [31:0] m_low, m_rx_rd, m_resp_rd;
  logic [3:0] m_ovf;
  logic [1:0] m_udf;
  bit model_on = 0;
  int n_c, n_t, n_r, n_p;

  always @(posedge clk) begin
    n_c = m_cmd.size(); n_t = m_tx.size(); n_r = m_rx.size(); n_p = m_resp.size();
    if (rst) begin
      m_cmd.delete(); m_tx.delete(); m_rx.delete(); m_resp.delete();
      m_half = 0; m_low = 0; m_rx_rd = 0; m_resp_rd = 0; m_ovf = 0; m_udf = 0;
      model_on = 1;
    end else if (soft_flush) begin
      m_cmd.delete(); m_tx.delete(); m_rx.delete(); m_resp.delete();
      m_half = 0;
      if (rx_rd_en) m_rx_rd = 0;
      if (resp_rd_en) m_resp_rd = 0;
    end else begin
      if (desc_pop && n_c > 0) void'(m_cmd.pop_front());
      if (cmd_wr_en) begin
        if (!m_half) begin m_low = cmd_wr_data; m_half = 1; end
        else begin
          m_half = 0;
          if (n_c < CD) m_cmd.push_back({cmd_wr_data, m_low}); else m_ovf[0] = 1;
        end
      end
      if (tx_pop && n_t > 0) void'(m_tx.pop_front());
      if (tx_wr_en) begin
        if (n_t < TD) m_tx.push_back(tx_wr_data); else m_ovf[1] = 1;
      end
      if (rx_rd_en) begin
        if (n_r > 0) m_rx_rd = m_rx.pop_front();
        else begin m_rx_rd = 0; m_udf[0] = 1; end
      end
      if (rx_push) begin
        if (n_r < RD) m_rx.push_back(rx_data); else m_ovf[2] = 1;
      end
      if (resp_rd_en) begin
        if (n_p > 0) m_resp_rd = m_resp.pop_front();
        else begin m_resp_rd = 0; m_udf[1] = 1; end
      end
      if (resp_push) begin
        if (n_p < PD) m_resp.push_back(resp_data); else m_ovf[3] = 1;
      end
    end
    #1;
    if (model_on && !done) begin
      chk("R3 cmd_count", cmd_count, m_cmd.size());
      chk("R3 tx_count", tx_count, m_tx.size());
      chk("R3 rx_count", rx_count, m_rx.size());
      chk("R3 resp_count", resp_count, m_resp.size());
      chk("R3 desc_valid", desc_valid, m_cmd.size() > 0);
      chk("R3 tx_valid", tx_valid, m_tx.size() > 0);
      if (m_cmd.size() > 0) chk("R2 desc_data", desc_data, m_cmd[0]);
      if (m_tx.size() > 0) chk("R3 tx_data", tx_data, m_tx[0]);
      chk("R6 rx_rd_data", rx_rd_data, m_rx_rd);
      chk("R6 resp_rd_data", resp_rd_data, m_resp_rd);
      chk("R4 ovf_flags", ovf_flags, m_ovf);
      chk("R5 udf_flags", udf_flags, m_udf);
      chk("R7 lvl_hit", lvl_hit, {m_resp.size() >= resp_lvl, m_rx.size() >= rx_lvl,
                                  m_tx.size() >= tx_lvl, m_cmd.size() >= cmd_lvl});
      chk("R9 rx_free", rx_free, RD - m_rx.size());
      chk("R9 resp_free", resp_free, PD - m_resp.size());
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic idle();
    cmd_wr_en = 0; tx_wr_en = 0; rx_rd_en = 0; resp_rd_en = 0;
    desc_pop = 0; tx_pop = 0; rx_push = 0; resp_push = 0; soft_flush = 0;
  endtask
  task automatic cmd_w(input logic [31:0] d);
    cmd_wr_en = 1; cmd_wr_data = d; step(); idle();
  endtask
  task automatic rx_p(input logic [31:0] d);
    rx_push = 1; rx_data = d; step(); idle();
  endtask
  task automatic resp_p(input logic [31:0] d);
    resp_push = 1; resp_data = d; step(); idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; idle();
    cmd_wr_data = 0; tx_wr_data = 0; rx_data = 0; resp_data = 0;
    cmd_lvl = 2; tx_lvl = 3; rx_lvl = 1; resp_lvl = 4;
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 counts", {cmd_count, tx_count, rx_count, resp_count}, 0);
    chk("R1 flags", {ovf_flags, udf_flags}, 0);
    chk("R1 rd data", {rx_rd_data, resp_rd_data}, 0);
    chk("R1 valid", {desc_valid, tx_valid}, 0);

    // R2 pairing: only one descriptor after the first word
    cmd_w(32'h1111_0000);
    chk("R2 no push after first word", cmd_count, 0);
    cmd_w(32'h2222_0000);
    chk("R2 descriptor order", desc_data, 64'h2222_0000_1111_0000);
    // R4 fill command queue beyond capacity
    for (int i = 0; i < 8; i++) cmd_w(32'hC000_0000 + i);
    chk("R4 cmd overflow flag", ovf_flags[0], 1);
    chk("R4 cmd full count", cmd_count, CD);
    // R8 flush with half-written descriptor
    cmd_w(32'hDEAD_0001);
    soft_flush = 1; tx_wr_en = 1; tx_wr_data = 32'h5; step(); idle();
    chk("R8 flushed counts", {cmd_count, tx_count}, 0);
    chk("R8 sticky kept", ovf_flags[0], 1);
    cmd_w(32'hAAAA_0001);
    cmd_w(32'hBBBB_0002);
    chk("R8 partial discarded", desc_data, 64'hBBBB_0002_AAAA_0001);
    // R5 empty reads
    rx_rd_en = 1; resp_rd_en = 1; step(); idle();
    chk("R5 empty read zero", {rx_rd_data, resp_rd_data}, 0);
    chk("R5 underflow", udf_flags, 2'b11);
    // R6 ordered reads and simultaneous push/pop
    rx_p(32'hA1); rx_p(32'hA2);
    rx_rd_en = 1; rx_push = 1; rx_data = 32'hA3; step(); idle();
    chk("R6 rx head read", rx_rd_data, 32'hA1);
    chk("R3 rx push+pop count", rx_count, 2);
    for (int i = 0; i < 6; i++) resp_p(32'hE0 + i);
    chk("R4 resp overflow", ovf_flags[3], 1);
    chk("R9 resp_free zero", resp_free, 0);
    // R7 level boundary
    resp_lvl = 4; #0.1;
    chk("R7 level equal", lvl_hit[3], 1);
    resp_rd_en = 1; step(); idle();
    chk("R7 level below", lvl_hit[3], 0);

    // mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      cmd_wr_en  = ($urandom % 3) == 0; cmd_wr_data = $urandom;
      tx_wr_en   = ($urandom % 3) == 0; tx_wr_data  = $urandom;
      rx_rd_en   = ($urandom % 3) == 0;
      resp_rd_en = ($urandom % 4) == 0;
      desc_pop   = ($urandom % 5) == 0;
      tx_pop     = ($urandom % 3) == 0;
      rx_push    = ($urandom % 3) == 0; rx_data = $urandom;
      resp_push  = ($urandom % 4) == 0; resp_data = $urandom;
      soft_flush = ($urandom % 97) == 0;
      cmd_lvl = 3'($urandom % 5); tx_lvl = 4'($urandom % 9);
      rx_lvl = 4'($urandom % 9);  resp_lvl = 3'($urandom % 5);
      step();
    end
    idle();
    repeat (2) step();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule